// File: doc/BRIEF.md
# Frame-Delimited Receive Sample Deframer

This block rebuilds parallel I/Q samples from the receive lanes of a source-synchronous converter link. Each core clock it takes a rising-edge lane word, a falling-edge lane word and the FRAME line sampled on both edges. The I/O capture stage in front of it has already produced these values. In double-data-rate mode a sample arrives as two half-words, one per edge. In single-data-rate mode a sample arrives as one full-width word on the rising edge only. A frame is a group of samples. The start and end of each group are found by matching the FRAME history against a fixed high-then-low pattern, not by a free-running counter.

The block carries either two I/Q channel pairs or one. The group length is four samples in the two-pair mode and two in the one-pair mode. In either case the block produces one sample per core clock. Each rebuilt sample is sign-extended to 16 bits and presented with a one-cycle valid strobe for its channel. Once locked, the block checks the FRAME pattern only at the expected group boundary. A mismatch there sets a sticky error flag, drops the group, and starts a new search that accepts the next matching group. The lane mode and channel mode are static configuration and must only change while reset is applied.

Top module: `rxdf_deframer`

## Requirements
- R1: In the two-pair mode a group carries four samples, oldest to newest I0, Q0, I1, Q1, and they appear on `i0_data`, `q0_data`, `i1_data`, `q1_data` respectively.
- R2: In double-data-rate mode each core clock carries one sample. The rising-edge word holds its upper half and the falling-edge word holds its lower half. Only the low HALF_W bits of `lane_rise` are used. In the two-pair mode the FRAME bits over the group's 8 edges (4 clocks), oldest first with rising before falling in each clock, must read 11110000.
- R3: In single-data-rate mode each core clock carries one full sample on `lane_rise`. `lane_fall` and `frm_fall` have no effect. In the two-pair mode the FRAME pattern over 4 rising edges is 1100.
- R4: For an accepted group, every valid strobe of the mode's channels is high for exactly one cycle. It rises after the second rising clock edge that follows the clock in which the group's last edge was presented. In the two-pair mode consecutive groups give strobes 4 clocks apart.
- R5: In the one-pair mode a group is I0 then Q0 with FRAME pattern 1100 (double rate) or 10 (single rate), strobes come 2 clocks apart, and `i1_valid` and `q1_valid` never assert.
- R6: Every output sample equals the 2*HALF_W-bit received sample sign-extended to 16 bits.
- R7: A FRAME mismatch at the expected boundary of a locked stream sets `frame_err`, which stays set until reset. That group gives no strobe, and the next group whose pattern matches is accepted and output.
- R8: Reset clears lock, `frame_err`, all strobes and all data outputs. No strobe asserts until a complete matching group has been received after reset, and a partial group is never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ddr_mode | input | 1 | 1: double-data-rate lanes, 0: single-data-rate lanes |
| one_ch | input | 1 | 1: one I/Q pair, 0: two I/Q pairs |
| lane_rise | input | 2*HALF_W | Lane word captured on the rising edge |
| lane_fall | input | HALF_W | Lane word captured on the falling edge |
| frm_rise | input | 1 | FRAME captured on the rising edge |
| frm_fall | input | 1 | FRAME captured on the falling edge |
| i0_data | output | OUT_W | Channel I0 sample |
| q0_data | output | OUT_W | Channel Q0 sample |
| i1_data | output | OUT_W | Channel I1 sample |
| q1_data | output | OUT_W | Channel Q1 sample |
| i0_valid | output | 1 | I0 sample strobe |
| q0_valid | output | 1 | Q0 sample strobe |
| i1_valid | output | 1 | I1 sample strobe |
| q1_valid | output | 1 | Q1 sample strobe |
| frame_err | output | 1 | Sticky FRAME boundary mismatch flag |

## Verification
Two things can fall on the same cycle: detecting a boundary mismatch and restarting the search for alignment. The cycle that flags the error is also the cycle in which the search must begin, or the group right behind it is lost. The bench provokes this by flipping only the last falling-edge FRAME bit of a group in a continuous double-data-rate stream, so that a good group follows immediately. It then checks three things: exactly the groups around the faulty one are output, with their own sample values and timing; the faulty group's samples never appear; and the error flag stays set.

// File: rtl/rxdf_pkg.sv
// Package: shared constants and mode decoding for the receive deframer.
// Assumes at most two I/Q pairs, so a group holds at most four samples.
package rxdf_pkg;

    localparam int SLOTS  = 4;          // samples in the largest group
    localparam int HIST_W = 2 * SLOTS;  // FRAME edges in the largest group

    // Number of core clocks (and samples) in one group.
    function automatic logic [2:0] group_len(input logic one);
        return one ? 3'd2 : 3'd4;
    endfunction

    // Expected FRAME history, newest edge in bit 0, right aligned.
    function automatic logic [HIST_W-1:0] frame_expect(input logic ddr, input logic one);
        case ({ddr, one})
            2'b10:   return 8'hF0;
            2'b11:   return 8'h0C;
            2'b00:   return 8'h0C;
            default: return 8'h02;
        endcase
    endfunction

    // Which history bits take part in the comparison.
    function automatic logic [HIST_W-1:0] frame_mask(input logic ddr, input logic one);
        case ({ddr, one})
            2'b10:   return 8'hFF;
            2'b11:   return 8'h0F;
            2'b00:   return 8'h0F;
            default: return 8'h03;
        endcase
    endfunction

endpackage

// File: rtl/rxdf_frame_track.sv
// Frame tracker: keeps the FRAME edge history and decides when a group
// is complete. While unlocked it tests the pattern every clock; once
// locked it tests only at the expected boundary. A mismatch there sets
// the sticky error and drops back to searching.
// Assumes modes are static outside reset.
module rxdf_frame_track
    import rxdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ddr_mode,
    input  logic one_ch,
    input  logic frm_rise,
    input  logic frm_fall,
    output logic grp_done,
    output logic frame_err
);

    logic [HIST_W-1:0] hist;
    logic              locked;
    logic [1:0]        phase;
    logic              match;
    logic              at_edge;
    logic [2:0]        last_idx;

    // Shift the captured FRAME edges into the history, rising edge first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (ddr_mode)
            hist <= {hist[HIST_W-3:0], frm_rise, frm_fall};
        else
            hist <= {hist[HIST_W-2:0], frm_rise};
    end

    // Compare the window with the pattern of the current mode.
    always_comb begin
        match    = ((hist ^ frame_expect(ddr_mode, one_ch)) & frame_mask(ddr_mode, one_ch)) == '0;
        last_idx = group_len(one_ch) - 3'd1;
        at_edge  = (phase == last_idx[1:0]);
        grp_done = match && (!locked || at_edge);
    end

    // Lock, boundary phase and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            phase     <= '0;
            frame_err <= 1'b0;
        end else if (grp_done) begin
            locked <= 1'b1;
            phase  <= '0;
        end else if (locked) begin
            if (at_edge) begin
                locked    <= 1'b0;
                phase     <= '0;
                frame_err <= 1'b1;
            end else begin
                phase <= phase + 2'd1;
            end
        end
    end

endmodule

// File: rtl/rxdf_sample_hist.sv
// Sample history: assembles one sample per clock (two half-words in
// double-data-rate mode, one full word otherwise) and keeps the last
// DEPTH samples, newest in slot 0.
module rxdf_sample_hist #(
    parameter int HALF_W = 6,
    parameter int DEPTH  = 4,
    localparam int SMP_W = 2 * HALF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ddr_mode,
    input  logic [SMP_W-1:0]            lane_rise,
    input  logic [HALF_W-1:0]           lane_fall,
    output logic [DEPTH-1:0][SMP_W-1:0] slots
);

    logic [SMP_W-1:0] fresh;

    // Build this clock's sample from the lane words.
    always_comb begin
        fresh = ddr_mode ? {lane_rise[HALF_W-1:0], lane_fall} : lane_rise;
    end

    // Newest slot takes the fresh sample.
    always_ff @(posedge clk) begin
        if (!rst_n) slots[0] <= '0;
        else        slots[0] <= fresh;
    end

    for (genvar j = 1; j < DEPTH; j++) begin : g_shift
        // Each older slot takes its younger neighbour.
        always_ff @(posedge clk) begin
            if (!rst_n) slots[j] <= '0;
            else        slots[j] <= slots[j-1];
        end
    end

endmodule

// File: rtl/rxdf_sext.sv
// Sign extender: widens a received sample to the output width.
// Assumes OUT_W >= IN_W.
module rxdf_sext #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    if (OUT_W > IN_W) begin : g_ext
        assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_same
        assign dout = din;
    end

endmodule

// File: rtl/rxdf_deframer.sv
// Receive deframer top: joins the frame tracker and the sample history,
// maps group slots to I/Q channels and registers the samples and strobes.
// Assumes lane words are already captured in the core clock domain.
module rxdf_deframer
    import rxdf_pkg::*;
#(
    parameter int HALF_W = 6,
    parameter int OUT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ddr_mode,
    input  logic                one_ch,
    input  logic [2*HALF_W-1:0] lane_rise,
    input  logic [HALF_W-1:0]   lane_fall,
    input  logic                frm_rise,
    input  logic                frm_fall,
    output logic [OUT_W-1:0]    i0_data,
    output logic [OUT_W-1:0]    q0_data,
    output logic [OUT_W-1:0]    i1_data,
    output logic [OUT_W-1:0]    q1_data,
    output logic                i0_valid,
    output logic                q0_valid,
    output logic                i1_valid,
    output logic                q1_valid,
    output logic                frame_err
);

    localparam int SMP_W = 2 * HALF_W;

    logic                        grp_done;
    logic [2:0]                  grp_len;
    logic [SLOTS-1:0][SMP_W-1:0] slots;
    logic [SLOTS-1:0][OUT_W-1:0] ext;
    logic [SLOTS-1:0][OUT_W-1:0] dat_q;
    logic [SLOTS-1:0]            vld_q;

    assign grp_len = group_len(one_ch);

    rxdf_frame_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ddr_mode  (ddr_mode),
        .one_ch    (one_ch),
        .frm_rise  (frm_rise),
        .frm_fall  (frm_fall),
        .grp_done  (grp_done),
        .frame_err (frame_err)
    );

    rxdf_sample_hist #(.HALF_W(HALF_W), .DEPTH(SLOTS)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .ddr_mode  (ddr_mode),
        .lane_rise (lane_rise),
        .lane_fall (lane_fall),
        .slots     (slots)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_ch
        localparam int TWO_IDX = SLOTS - 1 - k;
        localparam int ONE_IDX = (k < 2) ? (1 - k) : 0;
        logic [SMP_W-1:0] pick;
        logic             in_grp;

        // Choose the history slot that holds this channel's sample.
        always_comb begin
            pick   = one_ch ? slots[ONE_IDX] : slots[TWO_IDX];
            in_grp = (3'(k) < grp_len);
        end

        rxdf_sext #(.IN_W(SMP_W), .OUT_W(OUT_W)) u_sext (
            .din  (pick),
            .dout (ext[k])
        );

        // Register the channel sample and its one-cycle strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dat_q[k] <= '0;
                vld_q[k] <= 1'b0;
            end else begin
                vld_q[k] <= grp_done && in_grp;
                if (grp_done && in_grp) dat_q[k] <= ext[k];
            end
        end
    end

    assign i0_data  = dat_q[0];
    assign q0_data  = dat_q[1];
    assign i1_data  = dat_q[2];
    assign q1_data  = dat_q[3];
    assign i0_valid = vld_q[0];
    assign q0_valid = vld_q[1];
    assign i1_valid = vld_q[2];
    assign q1_valid = vld_q[3];

endmodule

// File: rtl/rxdf_chk.sv
// Checker for the receive deframer, bound to the top module.
// Relates strobes, data and the error flag over time.
module rxdf_chk #(
    parameter int SMP_W = 12,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             one_ch,
    input logic [OUT_W-1:0] i0_data,
    input logic [OUT_W-1:0] q1_data,
    input logic             i0_valid,
    input logic             q0_valid,
    input logic             i1_valid,
    input logic             q1_valid,
    input logic             frame_err
);

    // R1: both samples of a pair are strobed together.
    assert_pair_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i0_valid == q0_valid) && (i1_valid == q1_valid));

    // R4: in the two-pair mode a strobe is followed by three quiet clocks.
    assert_group_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (i0_valid && !one_ch) |=> !i0_valid ##1 !i0_valid ##1 !i0_valid);

    // R5: one-pair mode keeps the second pair silent; strobes never back to back.
    assert_second_pair_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (one_ch && $past(one_ch)) |-> (!i1_valid && !q1_valid));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        i0_valid |=> !i0_valid);

    // R6: upper output bits copy the sample sign.
    assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        i0_valid |-> ((&i0_data[OUT_W-1:SMP_W-1]) || !(|i0_data[OUT_W-1:SMP_W-1])));

    assert_sign_fill_q1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q1_valid |-> ((&q1_data[OUT_W-1:SMP_W-1]) || !(|q1_data[OUT_W-1:SMP_W-1])));

    // R7: the error flag never clears outside reset.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

endmodule

bind rxdf_deframer rxdf_chk #(.SMP_W(2*HALF_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .one_ch    (one_ch),
    .i0_data   (i0_data),
    .q1_data   (q1_data),
    .i0_valid  (i0_valid),
    .q0_valid  (q0_valid),
    .i1_valid  (i1_valid),
    .q1_valid  (q1_valid),
    .frame_err (frame_err)
);

// File: tb/tb_rxdf_deframer.sv
// Directed bench for the receive deframer: one task per scenario.
module tb_rxdf_deframer;

    localparam int HALF_W = 6;
    localparam int SMP_W  = 12;
    localparam int OUT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ddr_mode = 1'b1;
    logic              one_ch = 1'b0;
    logic [SMP_W-1:0]  lane_rise = '0;
    logic [HALF_W-1:0] lane_fall = '0;
    logic              frm_rise = 1'b0;
    logic              frm_fall = 1'b0;
    logic [OUT_W-1:0]  i0_data, q0_data, i1_data, q1_data;
    logic              i0_valid, q0_valid, i1_valid, q1_valid, frame_err;

    always #4 clk = ~clk;

    rxdf_deframer #(.HALF_W(HALF_W), .OUT_W(OUT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .one_ch(one_ch),
        .lane_rise(lane_rise), .lane_fall(lane_fall),
        .frm_rise(frm_rise), .frm_fall(frm_fall),
        .i0_data(i0_data), .q0_data(q0_data), .i1_data(i1_data), .q1_data(q1_data),
        .i0_valid(i0_valid), .q0_valid(q0_valid), .i1_valid(i1_valid), .q1_valid(q1_valid),
        .frame_err(frame_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [OUT_W-1:0] ev_d [16][4];
    int               ev_cyc [16];
    int               ev_n = 0;
    int               hi_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: log each strobe event with its cycle and samples.
    always @(negedge clk) begin
        if (rst_n) begin
            if (i0_valid && ev_n < 16) begin
                ev_d[ev_n][0] = i0_data;
                ev_d[ev_n][1] = q0_data;
                ev_d[ev_n][2] = i1_data;
                ev_d[ev_n][3] = q1_data;
                ev_cyc[ev_n]  = cyc;
                ev_n++;
            end
            if (i1_valid || q1_valid) hi_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SMP_W-1:0] smp(input int g, input int c);
        return SMP_W'((g * 4 + c + 1) * 695 + 2053);
    endfunction

    function automatic logic [OUT_W-1:0] sx(input logic [SMP_W-1:0] v);
        return {{(OUT_W-SMP_W){v[SMP_W-1]}}, v};
    endfunction

    task automatic do_reset(input bit ddr, input bit one);
        @(negedge clk);
        rst_n = 1'b0; ddr_mode = ddr; one_ch = one;
        lane_rise = '0; lane_fall = '0; frm_rise = 1'b0; frm_fall = 1'b0;
        repeat (3) @(negedge clk);
        ev_n = 0; hi_n = 0;
        rst_n = 1'b1;
    endtask

    // Drive one group; exp_cyc gets the cycle its strobe should be seen.
    task automatic send_group(input int g, input bit corrupt, output int exp_cyc);
        int glen;
        glen = one_ch ? 2 : 4;
        for (int c = 0; c < glen; c++) begin
            logic [SMP_W-1:0] s;
            bit fr;
            s  = smp(g, c);
            fr = (c < glen / 2);
            @(negedge clk);
            if (ddr_mode) begin
                lane_rise = {6'h15, s[SMP_W-1:HALF_W]};
                lane_fall = s[HALF_W-1:0];
                frm_rise  = fr;
                frm_fall  = (corrupt && c == glen - 1) ? ~fr : fr;
            end else begin
                lane_rise = s;
                lane_fall = 6'h2A ^ 6'(c);
                frm_rise  = (corrupt && c == glen - 1) ? ~fr : fr;
                frm_fall  = ~fr;
            end
            exp_cyc = cyc + 2;
        end
    endtask

    task automatic finish_idle();
        @(negedge clk);
        frm_rise = 1'b0; frm_fall = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic check_event(input int idx, input int g, input int exp_cyc, input string req);
        int glen;
        glen = one_ch ? 2 : 4;
        chk(ev_cyc[idx] == exp_cyc, req, "strobe cycle", ev_cyc[idx], exp_cyc);
        for (int k = 0; k < glen; k++)
            chk(ev_d[idx][k] == sx(smp(g, k)), req, "sample value", ev_d[idx][k], sx(smp(g, k)));
    endtask

    // R8: state right after reset.
    task automatic t_reset();
        do_reset(1'b1, 1'b0);
        #1;
        chk({i0_valid, q0_valid, i1_valid, q1_valid} == 4'b0, "R8", "strobes after reset",
            {i0_valid, q0_valid, i1_valid, q1_valid}, 0);
        chk({i0_data, q0_data, i1_data, q1_data} == '0, "R8", "data after reset", i0_data, 0);
        chk(frame_err == 1'b0, "R8", "error after reset", frame_err, 0);
    endtask

    // R1 R2 R4 R6: double-rate two-pair stream.
    task automatic t_ddr_two();
        int e [3];
        do_reset(1'b1, 1'b0);
        for (int g = 0; g < 3; g++) send_group(g, 1'b0, e[g]);
        finish_idle();
        chk(ev_n == 3, "R4", "group count", ev_n, 3);
        for (int g = 0; g < 3; g++) check_event(g, g, e[g], "R1_R2_R6");
        chk(ev_cyc[1] - ev_cyc[0] == 4, "R4", "strobe spacing", ev_cyc[1] - ev_cyc[0], 4);
        chk(frame_err == 1'b0, "R2", "no error", frame_err, 0);
    endtask

    // R3: single-rate two-pair stream with junk on the falling-edge inputs.
    task automatic t_sdr_two();
        int e [2];
        do_reset(1'b0, 1'b0);
        for (int g = 0; g < 2; g++) send_group(g + 3, 1'b0, e[g]);
        finish_idle();
        chk(ev_n == 2, "R3", "group count", ev_n, 2);
        for (int g = 0; g < 2; g++) check_event(g, g + 3, e[g], "R3");
        chk(frame_err == 1'b0, "R3", "no error", frame_err, 0);
    endtask

    // R5: one-pair stream in either lane mode.
    task automatic t_one_pair(input bit ddr);
        int e [3];
        do_reset(ddr, 1'b1);
        for (int g = 0; g < 3; g++) send_group(g + 6, 1'b0, e[g]);
        finish_idle();
        chk(ev_n == 3, "R5", "group count", ev_n, 3);
        for (int g = 0; g < 3; g++) check_event(g, g + 6, e[g], "R5");
        chk(ev_cyc[2] - ev_cyc[1] == 2, "R5", "strobe spacing", ev_cyc[2] - ev_cyc[1], 2);
        chk(hi_n == 0, "R5", "second pair strobes", hi_n, 0);
        chk(frame_err == 1'b0, "R5", "no error", frame_err, 0);
    endtask

    // R7: corrupt boundary, then back-to-back good groups.
    task automatic t_mismatch();
        int e [4];
        do_reset(1'b1, 1'b0);
        send_group(10, 1'b0, e[0]);
        send_group(11, 1'b1, e[1]);
        send_group(12, 1'b0, e[2]);
        send_group(13, 1'b0, e[3]);
        finish_idle();
        chk(ev_n == 3, "R7", "groups kept", ev_n, 3);
        check_event(0, 10, e[0], "R7");
        check_event(1, 12, e[2], "R7");
        check_event(2, 13, e[3], "R7");
        chk(frame_err == 1'b1, "R7", "error set", frame_err, 1);
        repeat (8) @(negedge clk);
        #1;
        chk(frame_err == 1'b1, "R7", "error held", frame_err, 1);
        do_reset(1'b1, 1'b0);
        #1;
        chk(frame_err == 1'b0, "R8", "error cleared by reset", frame_err, 0);
    endtask

    // R8: partial group after reset is not output.
    task automatic t_first_frame();
        int e;
        do_reset(1'b1, 1'b0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            lane_rise = 12'hABC; lane_fall = 6'h11;
            frm_rise = (c == 0); frm_fall = (c == 0);
        end
        send_group(5, 1'b0, e);
        finish_idle();
        chk(ev_n == 1, "R8", "only full group", ev_n, 1);
        check_event(0, 5, e, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ddr_two();
        t_sdr_two();
        t_one_pair(1'b1);
        t_one_pair(1'b0);
        t_mismatch();
        t_first_frame();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule